// File: doc/BRIEF.md
# Mixed-Sign Partitionable Multiplier Stage

This block multiplies two packed operand words. Depending on the lane width chosen at build time, it computes either one wide product or several narrower products at once. Each narrower product is independent of its neighbours. Two sign controls, one for every A lane and one for every B lane, choose whether the operands are read as two's complement or as unsigned. The result always keeps full precision.

A static parameter decides whether the products pass through an output register. With the register, the product appears one clock later, updates only while the clock enable is high, and clears on a synchronous reset. Without it, the product follows the inputs in the same cycle. A companion flag reports whether the product is to be read as signed. The block is meant to sit in front of adder or accumulator logic, which lies outside it.

Top module: `mixsign_mul_stage`

## Requirements
- R1: A sign input at 1 makes its operand two's complement (the top bit of each lane carries weight -2^(N-1)). A sign input at 0 makes it unsigned.
- R2: `prod_signed` is 1 when either sign input is 1. It is 0 only when both are 0, and it travels with the product it describes.
- R3: `sign_a` applies to every A lane and `sign_b` to every B lane in the same cycle. No lane uses a different signedness.
- R4: Lane k takes its operands from bits [k*N +: N] of each input word and writes its product to bits [k*2N +: 2N] of `prod`. The 2N-bit product is exact for all four sign combinations, including the all-ones unsigned case and the most-negative-squared case.
- R5: The lane count follows LANE_W: 36 gives 1 lane, 18 gives 4 lanes, and 9 gives 8 lanes. Lanes do not disturb one another.
- R6: With PIPE=1 and `ce` high, `prod` and `prod_signed` show the result of the inputs present at a clock edge from just after that edge, a latency of one cycle.
- R7: With PIPE=1 and `ce` low, `prod` and `prod_signed` keep their previous values whatever the inputs do.
- R8: With PIPE=1, `rst` high at a clock edge clears `prod` and `prod_signed` to zero, whatever the state of `ce`.
- R9: With PIPE=0, `prod` and `prod_signed` follow the inputs within the same cycle, and `clk`, `rst` and `ce` have no effect.
- R10: The sign inputs are captured together with the data. When the signs change from one cycle to the next, each product uses the signs that came with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high clear of the output register |
| ce | input | 1 | Load enable of the output register |
| sign_a | input | 1 | 1: A lanes are two's complement; 0: unsigned |
| sign_b | input | 1 | 1: B lanes are two's complement; 0: unsigned |
| a_in | input | LANES*LANE_W | Packed A operands, lane 0 in the low bits |
| b_in | input | LANES*LANE_W | Packed B operands, lane 0 in the low bits |
| prod | output | 2*LANES*LANE_W | Packed full-precision products, lane 0 in the low bits |
| prod_signed | output | 1 | 1 when the product is to be read as signed |

## Verification
The bench targets the extreme operands in each sign combination: all ones times all ones unsigned, the most negative value squared, and a negative value times a large unsigned one. A design that dropped the extension bit, or extended with the wrong bit, would produce wrong upper product bits in exactly these cases. Distinct per-lane patterns on the 4-lane and 8-lane builds expose swapped or overlapping lane slices. Back-to-back sign changes show any misalignment between the sign controls and the data. Holds with the enable low and resets in mid-stream show a register that loads, or fails to clear, at the wrong time.

// File: rtl/mulp_pkg.sv
`timescale 1ns/1ps
package mulp_pkg;
  // number of parallel lanes for a given lane width
  function automatic int lanes_for(input int lane_w);
    if (lane_w >= 36) return 1;
    else if (lane_w >= 18) return 4;
    else return 8;
  endfunction
endpackage

// File: rtl/mulp_lane.sv
`timescale 1ns/1ps
module mulp_lane #(
  parameter int N = 18
) (
  input  logic           sa,
  input  logic           sb,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int XW = N + 1;
  localparam int FW = 2 * XW;

  // one extra bit: copy of the top bit when signed, zero otherwise
  function automatic logic signed [XW-1:0] widen(input logic [N-1:0] v, input logic s);
    return $signed({s & v[N-1], v});
  endfunction

  function automatic logic [2*N-1:0] mul_lane(input logic [N-1:0] x, input logic [N-1:0] y,
                                              input logic sx, input logic sy);
    logic signed [FW-1:0] full;
    full = FW'(widen(x, sx)) * FW'(widen(y, sy));
    return full[2*N-1:0];
  endfunction

  assign p = mul_lane(a, b, sa, sb);
endmodule

// File: rtl/mulp_stage_reg.sv
`timescale 1ns/1ps
module mulp_stage_reg #(
  parameter int W    = 144,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  input  logic         d_sgn,
  output logic [W-1:0] q,
  output logic         q_sgn
);
  if (PIPE) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q     <= '0;
        q_sgn <= 1'b0;
      end else if (ce) begin
        q     <= d;
        q_sgn <= d_sgn;
      end
    end
  end else begin : g_pass
    assign q     = d;
    assign q_sgn = d_sgn;
  end
endmodule

// File: rtl/mixsign_mul_stage.sv
`timescale 1ns/1ps
module mixsign_mul_stage #(
  parameter int LANE_W = 18,
  parameter bit PIPE   = 1'b1,
  localparam int LANES = mulp_pkg::lanes_for(LANE_W),
  localparam int A_W   = LANES * LANE_W,
  localparam int P_W   = 2 * A_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           sign_a,
  input  logic           sign_b,
  input  logic [A_W-1:0] a_in,
  input  logic [A_W-1:0] b_in,
  output logic [P_W-1:0] prod,
  output logic           prod_signed
);
  localparam int PL_W = 2 * LANE_W;

  // named internal events for the checker
  logic [P_W-1:0] raw_prod;
  logic           raw_signed;

  assign raw_signed = sign_a | sign_b;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mulp_lane #(.N(LANE_W)) u_lane (
      .sa (sign_a),
      .sb (sign_b),
      .a  (a_in[k*LANE_W +: LANE_W]),
      .b  (b_in[k*LANE_W +: LANE_W]),
      .p  (raw_prod[k*PL_W +: PL_W])
    );
  end

  mulp_stage_reg #(.W(P_W), .PIPE(PIPE)) u_oreg (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .d     (raw_prod),
    .d_sgn (raw_signed),
    .q     (prod),
    .q_sgn (prod_signed)
  );
endmodule

// File: rtl/mixsign_mul_stage_chk.sv
`timescale 1ns/1ps
module mixsign_mul_stage_chk #(
  parameter int LANE_W = 18,
  parameter bit PIPE   = 1'b1,
  localparam int LANES = mulp_pkg::lanes_for(LANE_W),
  localparam int A_W   = LANES * LANE_W,
  localparam int P_W   = 2 * A_W
) (
  input logic           clk,
  input logic           rst,
  input logic           ce,
  input logic           sign_a,
  input logic           sign_b,
  input logic [A_W-1:0] a_in,
  input logic [A_W-1:0] b_in,
  input logic [P_W-1:0] raw_prod,
  input logic [P_W-1:0] prod,
  input logic           prod_signed
);
  localparam int PL_W = 2 * LANE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R4: a zero operand in a lane gives a zero product in that lane slot only
    a_r4_zero_lane: assert property (@(posedge clk) disable iff (rst)
      (a_in[k*LANE_W +: LANE_W] == '0) |-> (raw_prod[k*PL_W +: PL_W] == '0));
  end

  if (PIPE) begin : g_pipe_chk
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
      ce |=> (prod == $past(raw_prod)));
    a_r2_flag: assert property (@(posedge clk) disable iff (rst)
      ce |=> (prod_signed == $past(sign_a | sign_b)));
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(prod) && $stable(prod_signed)));
    a_r8_clear: assert property (@(posedge clk)
      rst |=> (prod == '0 && !prod_signed));
  end
endmodule

bind mixsign_mul_stage mixsign_mul_stage_chk #(.LANE_W(LANE_W), .PIPE(PIPE)) u_chk (.*);

// File: tb/mixsign_mul_stage_tb.sv
`timescale 1ns/1ps
module mixsign_mul_stage_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        sg_a = 1'b0;
  logic        sg_b = 1'b0;
  logic [71:0] a_bus = '0;
  logic [71:0] b_bus = '0;

  logic [143:0] p18;
  logic [143:0] p9;
  logic [71:0]  p36;
  logic         s18, s9, s36;

  mixsign_mul_stage #(.LANE_W(18), .PIPE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .sign_a(sg_a), .sign_b(sg_b),
    .a_in(a_bus), .b_in(b_bus), .prod(p18), .prod_signed(s18));

  mixsign_mul_stage #(.LANE_W(9), .PIPE(1'b0)) u_byp (
    .clk(clk), .rst(rst), .ce(ce), .sign_a(sg_a), .sign_b(sg_b),
    .a_in(a_bus), .b_in(b_bus), .prod(p9), .prod_signed(s9));

  mixsign_mul_stage #(.LANE_W(36), .PIPE(1'b1)) u_w36 (
    .clk(clk), .rst(rst), .ce(ce), .sign_a(sg_a), .sign_b(sg_b),
    .a_in(a_bus[35:0]), .b_in(b_bus[35:0]), .prod(p36), .prod_signed(s36));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [143:0] hold18 = '0;
  logic [143:0] hold36 = '0;
  logic         hold_s = 1'b0;

  // reference: value of each lane as an integer, exact product, then slot placement
  function automatic logic [143:0] model(input logic [71:0] a, input logic [71:0] b,
                                         input bit sa, input bit sb, input int n, input int lanes);
    logic [143:0] acc = '0;
    for (int k = 0; k < lanes; k++) begin
      logic signed [79:0] va, vb, pr;
      logic [79:0] msk;
      logic [143:0] slot;
      msk = (80'd1 << n) - 80'd1;
      va = 80'(a >> (k * n)) & msk;
      vb = 80'(b >> (k * n)) & msk;
      if (sa && va[n-1]) va = va - (80'sd1 <<< n);
      if (sb && vb[n-1]) vb = vb - (80'sd1 <<< n);
      pr = va * vb;
      slot = 144'(pr & ((80'd1 << (2 * n)) - 80'd1));
      acc = acc | (slot << (2 * n * k));
    end
    return acc;
  endfunction

  task automatic chk(input string tag, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check bypass build, then check registered builds after the edge
  task automatic step(input logic [71:0] a, input logic [71:0] b, input bit sa, input bit sb,
                      input bit ce_v, input bit rst_v, input string tag);
    logic [143:0] e9, e18, e36;
    @(negedge clk);
    a_bus = a; b_bus = b; sg_a = sa; sg_b = sb; ce = ce_v; rst = rst_v;
    #1;
    e9  = model(a, b, sa, sb, 9, 8);
    e18 = model(a, b, sa, sb, 18, 4);
    e36 = model({36'd0, a[35:0]}, {36'd0, b[35:0]}, sa, sb, 36, 1);
    chk({tag, " R9 bypass 9x9"}, p9, e9);
    chk({tag, " R9 R2 bypass flag"}, {143'd0, s9}, {143'd0, sa | sb});
    if (rst_v) begin
      hold18 = '0; hold36 = '0; hold_s = 1'b0;
    end else if (ce_v) begin
      hold18 = e18; hold36 = e36; hold_s = sa | sb;
    end
    @(posedge clk);
    #1;
    chk({tag, " R6 18x18"}, p18, hold18);
    chk({tag, " R6 36x36"}, {72'd0, p36}, hold36);
    chk({tag, " R2 flag"}, {142'd0, s36, s18}, {142'd0, hold_s, hold_s});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8 reset state 18", p18, '0);
    chk("R8 reset state 36", {72'd0, p36}, '0);
    chk("R8 reset flag", {142'd0, s36, s18}, '0);
  endtask

  task automatic t_extremes;
    step({72{1'b1}}, {72{1'b1}}, 0, 0, 1, 0, "R4 R1 all-ones unsigned");
    step({8{9'h100}}, {8{9'h100}}, 1, 1, 1, 0, "R4 R1 min squared");
    step({4{18'h20000}}, {4{18'h20000}}, 1, 1, 1, 0, "R4 R1 min18 squared");
    step({72{1'b1}}, {72{1'b1}}, 1, 0, 1, 0, "R1 R3 signed A unsigned B");
    step({4{18'h20000}}, {72{1'b1}}, 0, 1, 1, 0, "R1 R3 unsigned A signed B");
    step({36'd0, 36'h8_0000_0000}, {36'd0, 36'hF_FFFF_FFFF}, 1, 0, 1, 0, "R1 36 wide mixed");
  endtask

  task automatic t_lanes;
    step(72'h01_23_45_67_89_AB_CD_EF_F0, 72'hFE_DC_BA_98_76_54_32_10_0F, 1, 1, 1, 0, "R5 R3 distinct lanes");
    step(72'h00_00_00_00_00_00_00_00_FF, 72'h1FF_FFFF_FFFF_FFFF_FF, 0, 1, 1, 0, "R5 single active lane");
  endtask

  task automatic t_sign_switch;
    step(72'hF00F_F00F_F00F_F00F_F0, 72'h8765_4321_0FED_CBA9_87, 0, 0, 1, 0, "R10 signs 00");
    step(72'hF00F_F00F_F00F_F00F_F0, 72'h8765_4321_0FED_CBA9_87, 1, 1, 1, 0, "R10 signs 11");
    step(72'hF00F_F00F_F00F_F00F_F0, 72'h8765_4321_0FED_CBA9_87, 0, 1, 1, 0, "R10 signs 01");
  endtask

  task automatic t_hold;
    step(72'h3_0000_1234_5678_9ABC, 72'h7_FFFF_EDCB_A987_6543, 1, 0, 1, 0, "R7 load before hold");
    step({72{1'b1}}, 72'h5A5A_5A5A_5A5A_5A5A_5A, 1, 1, 0, 0, "R7 hold ce low");
    step(72'h1234_5678_9ABC_DEF0_12, 72'h0, 0, 0, 0, 0, "R7 hold second cycle");
  endtask

  task automatic t_midreset;
    step(72'hABCD_EF01_2345_6789_AB, 72'h1357_9BDF_0246_8ACE_13, 1, 1, 1, 1, "R8 reset with ce high");
    step(72'hABCD_EF01_2345_6789_AB, 72'h1357_9BDF_0246_8ACE_13, 1, 1, 0, 1, "R8 reset with ce low");
    step(72'hABCD_EF01_2345_6789_AB, 72'h1357_9BDF_0246_8ACE_13, 1, 0, 1, 0, "R6 after reset");
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 40; i++) begin
      logic [71:0] ra, rb;
      ra = {$urandom(), $urandom(), $urandom()};
      rb = {$urandom(), $urandom(), $urandom()};
      step(ra, rb, 1'($urandom()), 1'($urandom()), 1'($urandom()), 0, "R4 sweep");
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_extremes();
    t_lanes();
    t_sign_switch();
    t_hold();
    t_midreset();
    t_sweep();
    finish_run();
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule